// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked shift mode of a small controller's serial port. One pin carries serial data in both directions (half duplex). The other pin carries a shift clock that the block generates. The shift clock runs at a fixed rate of one period per twelve oscillator clocks, and each transfer moves eight bits, least significant bit first.

Software starts a transfer implicitly; there is no separate start command:
- A write to the data buffer while the port is idle sends that byte.
- A control-register write that clears the receive-complete flag, with receive enabled, clocks in a byte from the data pin.

Two flags in the control register report the end of a transfer: a transmit-complete flag and a receive-complete flag. Hardware only ever sets them; software clears them by writing the register.

Top module: `sync_shift_port`

## Requirements
- R1: The shift clock idles high. During a transfer, each bit slot lasts 12 clock cycles, numbered 0 to 11 from the start of the slot. The shift clock is low in cycles 4 to 9 and high in cycles 10, 11 and 0 to 3. A transfer lasts 8 slots (96 cycles).
- R2: A buffer write while idle starts a transmission. Bit k of the written byte (LSB first) is driven on the data output for the 12 cycles of slot k, with the output enable high for the whole transfer.
- R3: At the end of a transmission, control bit 1 (transmit-complete) becomes 1 and the port returns to idle.
- R4: A reception starts only when all of the following hold:
  - the port is idle;
  - control bit 0 (receive-complete) is currently 1;
  - a control write carries bit 0 = 0 and bit 4 (receive enable) = 1.

  The input pin is sampled on the clock edge that ends slot cycle 9, which is where the shift clock rises, and bits are collected LSB first. After 96 cycles, the received byte appears on rd_data and control bit 0 becomes 1.
- R5: During a transmission, the data output changes only at slot boundaries. This gives 10 cycles of setup before the shift-clock rise and 2 cycles of hold after it.
- R6: While idle or receiving, the data output is 1 and its output enable is 0.
- R7: Control register layout:
  - bits 7:5: mode bits, stored and read back;
  - bit 4: receive enable;
  - bit 3: transmit ninth bit, stored;
  - bit 2: received ninth bit, stored;
  - bit 1: transmit-complete;
  - bit 0: receive-complete.

  A control write loads all eight bits. Hardware never clears bits 1 or 0.
- R8: After reset, the control register and rd_data are 0, the shift clock is high, the data output is 1 and the output enable is 0.
- R9: A buffer write, or a clearing of the receive-complete flag, while a transfer is in progress is ignored.
- R10: Two rules settle events that fall on the same edge:
  - If a control write lands on the edge where a transfer completes, the hardware setting of the flag wins.
  - A buffer write and a receive-start write on the same idle edge start a transmission only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_buf | input | 1 | Data buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register read value |
| sdi | input | 1 | Serial data pin, input side |
| sdo | output | 1 | Serial data pin, output side |
| sdo_oe | output | 1 | Output enable for the serial data pin |
| sclk | output | 1 | Shift clock |

## Verification
The completion of a transfer and a software write to the control register can land on the same edge. In that case the hardware flag set and the software value collide. The bench provokes this by issuing a control write that clears both flags exactly on the 96th edge of a reception. It expects the receive-complete flag to read 1 afterwards, with the other bits as written. A second collision, a buffer write and a receive-start write on one idle edge, is judged by observing that the output enable rises and that no reception is started.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DW  = 8,
  parameter int CYC = 12,
  parameter int LOW_BEG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_buf,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          sclk
);
  localparam int PW = $clog2(CYC);
  localparam int BW = $clog2(DW);
  localparam int LOW_END = LOW_BEG + CYC / 2;
  localparam int SAMPLE = LOW_END - 1;

  logic          busy, dir_tx, ti_q, ri_q;
  logic [PW-1:0] phase;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] sh, rxbuf;
  logic [5:0]    ctl_hi;

  wire last_ph  = phase == PW'(CYC - 1);
  wire done     = busy && last_ph && bitcnt == BW'(DW - 1);
  wire start_tx = !busy && wr_buf;
  wire start_rx = !busy && !wr_buf && ctl_wr && ri_q && !ctl_wdata[0] && ctl_wdata[4];

  assign sclk      = !(busy && phase >= PW'(LOW_BEG) && phase < PW'(LOW_END));
  assign sdo_oe    = busy && dir_tx;
  assign sdo       = sdo_oe ? sh[0] : 1'b1;
  assign rd_data   = rxbuf;
  assign ctl_rdata = {ctl_hi, ti_q, ri_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dir_tx <= 1'b0;
      phase  <= '0;
      bitcnt <= '0;
      sh     <= '0;
      rxbuf  <= '0;
      ctl_hi <= '0;
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_hi <= ctl_wdata[7:2];
        ti_q   <= ctl_wdata[1];
        ri_q   <= ctl_wdata[0];
      end
      if (busy) begin
        if (!dir_tx && phase == PW'(SAMPLE))
          sh <= {sdi, sh[DW-1:1]};
        if (last_ph) begin
          phase  <= '0;
          bitcnt <= bitcnt + BW'(1);
          if (dir_tx) sh <= {1'b1, sh[DW-1:1]};
        end else begin
          phase <= phase + PW'(1);
        end
        if (done) begin
          busy <= 1'b0;
          if (dir_tx) ti_q <= 1'b1;
          else begin
            ri_q  <= 1'b1;
            rxbuf <= sh;
          end
        end
      end else if (start_tx) begin
        busy   <= 1'b1;
        dir_tx <= 1'b1;
        sh     <= wr_data;
        phase  <= '0;
        bitcnt <= '0;
      end else if (start_rx) begin
        busy   <= 1'b1;
        dir_tx <= 1'b0;
        phase  <= '0;
        bitcnt <= '0;
      end
    end
  end

  AST_TI_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ti_q) && !$past(ctl_wr)) |-> ($past(busy && dir_tx) && !busy)); // R3
  AST_RI_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ri_q) && !$past(ctl_wr)) |-> ($past(busy && !dir_tx) && !busy)); // R4
  AST_SDO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && $past(phase) != PW'(CYC - 1)) |-> $stable(sdo)); // R5
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_buf && !last_ph) |=> (busy && $stable(bitcnt) && $stable(dir_tx))); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && sclk)); // R1
endmodule

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;
  logic clk = 0, rst_n = 0, wr_buf = 0, ctl_wr = 0, sdi = 1;
  logic [7:0] wr_data = 0, ctl_wdata = 0, rd_data, ctl_rdata;
  logic sdo, sdo_oe, sclk;
  int checks = 0, errors = 0, cyc = 0;
  int m_busy = 0, m_tx = 0, m_cnt = 0, m_txsh = 0, m_rxsh = 0, m_rd = 0, m_ctl = 0;
  logic [7:0] pat = 8'h6B;

  always #2 clk = ~clk;

  sync_shift_port uut (.clk(clk), .rst_n(rst_n), .wr_buf(wr_buf), .wr_data(wr_data),
    .rd_data(rd_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .sclk(sclk));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int old_busy, old_ri;
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_tx = 0; m_cnt = 0; m_txsh = 0; m_rxsh = 0; m_rd = 0; m_ctl = 0;
    end else begin
      old_busy = m_busy;
      old_ri = m_ctl & 1;
      if (ctl_wr) m_ctl = ctl_wdata;
      if (old_busy != 0) begin
        if (m_tx == 0 && m_cnt % 12 == 9) m_rxsh = (m_rxsh >> 1) | (int'(sdi) << 7);
        if (m_tx != 0 && m_cnt % 12 == 11) m_txsh = m_txsh >> 1;
        if (m_cnt == 95) begin
          m_busy = 0;
          if (m_tx != 0) m_ctl = m_ctl | 2;
          else begin m_ctl = m_ctl | 1; m_rd = m_rxsh; end
        end else m_cnt++;
      end else if (wr_buf) begin
        m_busy = 1; m_tx = 1; m_cnt = 0; m_txsh = wr_data;
      end else if (ctl_wr && old_ri != 0 && !ctl_wdata[0] && ctl_wdata[4]) begin
        m_busy = 1; m_tx = 0; m_cnt = 0; m_rxsh = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (m_busy != 0 && m_tx == 0)
      sdi <= (m_cnt % 12 == 9) ? pat[m_cnt / 12] : ~pat[m_cnt / 12];
    else
      sdi <= 1'b1;
    if (rst_n) begin
      chk("R1 sclk", sclk, !(m_busy != 0 && m_cnt % 12 >= 4 && m_cnt % 12 <= 9));
      chk("R2/R5 sdo", sdo, (m_busy != 0 && m_tx != 0) ? (m_txsh & 1) : 1);
      chk("R6 sdo_oe", sdo_oe, m_busy != 0 && m_tx != 0);
      chk("R7 ctl_rdata", ctl_rdata, m_ctl);
      chk("R4 rd_data", rd_data, m_rd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [7:0] d);
    @(negedge clk); wr_buf = 1; wr_data = d;
    @(negedge clk); wr_buf = 0;
  endtask

  task automatic ctl_write(logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wait_idle();
    while (m_busy != 0) @(negedge clk);
  endtask

  initial begin
    idle(3);
    chk("R8 ctl reset", ctl_rdata, 0);
    chk("R8 rd reset", rd_data, 0);
    chk("R8 pins reset", {sclk, sdo, sdo_oe}, 3'b110);
    rst_n = 1;
    idle(2);
    wr_byte(8'hA5);
    chk("R2 oe after write", sdo_oe, 1);
    idle(28);
    wr_byte(8'h3C);
    chk("R9 write while busy keeps tx", sdo_oe, 1);
    wait_idle();
    idle(1);
    chk("R3 ti set", ctl_rdata[1], 1);
    ctl_write(8'h10);
    idle(10);
    chk("R4 no rx without ri set", sclk, 1);
    ctl_write(8'h11);
    ctl_write(8'h10);
    idle(20);
    ctl_write(8'h10);
    wait_idle();
    idle(1);
    chk("R4 received byte", rd_data, 8'h6B);
    chk("R4 ri set", ctl_rdata[0], 1);
    pat = 8'h92;
    ctl_write(8'h10);
    ctl_write(8'h11);
    ctl_write(8'h10);
    while (!(m_busy != 0 && m_cnt == 95)) @(negedge clk);
    ctl_wr = 1; ctl_wdata = 8'hE8;
    @(negedge clk); ctl_wr = 0;
    chk("R10 hw set wins", ctl_rdata, 8'hE9);
    chk("R4 second byte", rd_data, 8'h92);
    ctl_write(8'h11);
    @(negedge clk); wr_buf = 1; wr_data = 8'h81; ctl_wr = 1; ctl_wdata = 8'h10;
    @(negedge clk); wr_buf = 0; ctl_wr = 0;
    chk("R10 tx wins over rx start", sdo_oe, 1);
    wait_idle();
    ctl_write(8'h01);
    ctl_write(8'h00);
    idle(15);
    chk("R4 rx disabled", sclk, 1);
    wr_byte(8'hFF);
    wait_idle();
    wr_byte(8'h00);
    wait_idle();
    idle(4);
    chk("R7 flags kept", ctl_rdata[1], 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog at cycle %0d: actual hung expected finished", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule